// File: doc/BRIEF.md
# External Bus Cycle Timing Controller

This block sequences one cycle on an external memory or peripheral bus. When a requester raises a start request, the block drives the address phase and pulses an address strobe. It pulls the active-low chip select after a programmable setup delay. It then counts wait states per beat and terminates each beat either with an internal auto-acknowledge or, when that is disabled, on an acknowledge from the external device. After the final beat it keeps the address phase alive for a programmable hold time before going idle.

Every timing field is sampled when the start request is accepted, so each cycle can use its own timing. The requester marks the final beat of a burst with a last-beat input. Beats after the first can optionally use a second wait count. Read hold time depends on whether auto-acknowledge is on; write hold time does not. Address decode and byte-lane steering sit outside this block.

Top module: `bus_cycle_timer`

## Requirements
- R1: A start accepted while idle asserts addr_drive and addr_strobe in the next cycle. cs_n goes low on the (setup_code+1)-th rising edge after that acceptance, so setup codes 0..3 give 1..4 cycles of address before chip select.
- R2: With strobe_ext = 0, addr_strobe is high for exactly one cycle. With strobe_ext = 1, it stays high until the first rising edge after cs_n goes low, for setup_code+2 cycles in total.
- R3: With auto_ack_en = 1, a beat is acknowledged in its (W+1)-th chip-select cycle, where W is the 6-bit wait count that applies to that beat.
- R4: With auto_ack_en = 0, no internal acknowledge is produced and the wait counts have no effect. A beat completes only in a cycle where ext_ack is high while cs_n is low.
- R5: With sec_wait_en = 1, beats after the first use wait_sec and the first beat uses wait_pri. With sec_wait_en = 0, every beat uses wait_pri.
- R6: beat_ack is a one-cycle pulse for each completed beat and is only high while cs_n is low. cs_n stays low between beats and rises after the acknowledge of the beat whose last_beat input is high.
- R7: On a write (is_read = 0), addr_drive stays high with cs_n high for wr_hold_code+1 cycles after chip select negates (codes 0..3 give 1..4 cycles).
- R8: On a read (is_read = 1), the hold lasts rd_hold_code+1 cycles when auto_ack_en = 0 and rd_hold_code cycles when auto_ack_en = 1. A hold of 0 drops addr_drive in the same cycle as cs_n rises.
- R9: A start request is ignored while a cycle is in progress, including during its hold phase. A new cycle begins only from idle.
- R10: After reset, cs_n is high and addr_drive, addr_strobe, beat_ack and hold_phase are low.
- R11: The timing fields and is_read are captured when the start is accepted. Changing them during a cycle does not change that cycle's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a bus cycle (accepted only while idle) |
| is_read | input | 1 | 1 = read cycle, 0 = write cycle |
| last_beat | input | 1 | High when the beat now in progress is the final one |
| ext_ack | input | 1 | Acknowledge from the external device |
| setup_code | input | 2 | Address-to-chip-select setup code |
| wait_pri | input | 6 | Wait count for the first beat (and all beats when sec_wait_en = 0) |
| wait_sec | input | 6 | Wait count for follow-on burst beats |
| sec_wait_en | input | 1 | Enables wait_sec for follow-on beats |
| auto_ack_en | input | 1 | Enables the internal acknowledge |
| wr_hold_code | input | 2 | Address hold code for writes |
| rd_hold_code | input | 2 | Address hold code for reads |
| strobe_ext | input | 1 | Stretches the address strobe up to chip select |
| addr_drive | output | 1 | Address and attributes are being driven |
| addr_strobe | output | 1 | Address strobe |
| cs_n | output | 1 | Active-low chip select |
| beat_ack | output | 1 | One-cycle acknowledge per completed beat |
| hold_phase | output | 1 | Address hold after chip select negates |

## Verification
The bound checker watches properties that hold on every cycle regardless of programming:
- a new address phase always opens with the strobe;
- acknowledges occur only under chip select;
- without auto-acknowledge an acknowledge always coincides with ext_ack;
- the strobe overlaps chip select by at most one cycle;
- the hold phase keeps the address with chip select negated;
- no new strobe follows a hold cycle.

The exact counts cannot be seen by those properties: setup length, strobe width, per-beat wait latency, the choice between primary and secondary wait counts, and read versus write hold length. The bench's directed scenarios show these by timing whole cycles against values derived from the codes. The same applies to rejecting a held start request and to capturing the configuration at start.

// File: rtl/bct_pkg.sv
package bct_pkg;

    localparam int CODE_W = 2;
    localparam int WAIT_W = 6;
    localparam int HOLD_W = CODE_W + 1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_DATA  = 2'd2,
        ST_HOLD  = 2'd3
    } bct_state_e;

    typedef struct packed {
        logic              is_read;
        logic [CODE_W-1:0] setup;
        logic [WAIT_W-1:0] wait_pri;
        logic [WAIT_W-1:0] wait_sec;
        logic              sec_en;
        logic              auto_ack;
        logic [CODE_W-1:0] wr_hold;
        logic [CODE_W-1:0] rd_hold;
        logic              strobe_ext;
    } bct_cfg_t;

    // Number of hold cycles after chip select negates.
    function automatic logic [HOLD_W-1:0] hold_len(bct_cfg_t c);
        if (c.is_read)
            return HOLD_W'(c.rd_hold) + HOLD_W'(!c.auto_ack);
        else
            return HOLD_W'(c.wr_hold) + HOLD_W'(1);
    endfunction

    // Wait count for a beat that follows another beat of the same burst.
    function automatic logic [WAIT_W-1:0] follow_wait(bct_cfg_t c);
        return c.sec_en ? c.wait_sec : c.wait_pri;
    endfunction

endpackage

// File: rtl/bct_cfg_reg.sv
module bct_cfg_reg
    import bct_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  bct_cfg_t d,
    output bct_cfg_t q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end
endmodule

// File: rtl/bct_seq.sv
module bct_seq
    import bct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CODE_W-1:0] setup_live,
    input  bct_cfg_t          cfg,
    input  logic              ext_ack,
    input  logic              last_beat,
    output bct_state_e        state,
    output logic              accept,
    output logic              beat_done
);
    logic [WAIT_W-1:0] cnt;
    logic [HOLD_W-1:0] hold_cycles;

    assign accept      = (state == ST_IDLE) && start;
    assign hold_cycles = hold_len(cfg);
    assign beat_done   = (state == ST_DATA) &&
                         (cfg.auto_ack ? (cnt == '0) : ext_ack);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_SETUP;
                        cnt   <= WAIT_W'(setup_live);
                    end
                end
                ST_SETUP: begin
                    if (cnt == '0) begin
                        state <= ST_DATA;
                        cnt   <= cfg.wait_pri;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_DATA: begin
                    if (beat_done) begin
                        if (!last_beat) begin
                            cnt <= follow_wait(cfg);
                        end else if (hold_cycles == '0) begin
                            state <= ST_IDLE;
                        end else begin
                            state <= ST_HOLD;
                            cnt   <= WAIT_W'(hold_cycles) - 1'b1;
                        end
                    end else if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (cnt == '0)
                        state <= ST_IDLE;
                    else
                        cnt <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bct_strobe_gen.sv
module bct_strobe_gen
    import bct_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  bct_state_e state,
    input  logic       stretch,
    output logic       strobe
);
    always_ff @(posedge clk) begin
        if (rst)
            strobe <= 1'b0;
        else
            strobe <= accept || (stretch && state == ST_SETUP);
    end
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
    import bct_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_read,
    input  logic              last_beat,
    input  logic              ext_ack,
    input  logic [CODE_W-1:0] setup_code,
    input  logic [WAIT_W-1:0] wait_pri,
    input  logic [WAIT_W-1:0] wait_sec,
    input  logic              sec_wait_en,
    input  logic              auto_ack_en,
    input  logic [CODE_W-1:0] wr_hold_code,
    input  logic [CODE_W-1:0] rd_hold_code,
    input  logic              strobe_ext,
    output logic              addr_drive,
    output logic              addr_strobe,
    output logic              cs_n,
    output logic              beat_ack,
    output logic              hold_phase
);
    bct_cfg_t   cfg_in;
    bct_cfg_t   cfg_q;
    bct_state_e state;
    logic       accept;
    logic       beat_done;
    logic       auto_q;

    always_comb begin
        cfg_in.is_read    = is_read;
        cfg_in.setup      = setup_code;
        cfg_in.wait_pri   = wait_pri;
        cfg_in.wait_sec   = wait_sec;
        cfg_in.sec_en     = sec_wait_en;
        cfg_in.auto_ack   = auto_ack_en;
        cfg_in.wr_hold    = wr_hold_code;
        cfg_in.rd_hold    = rd_hold_code;
        cfg_in.strobe_ext = strobe_ext;
    end

    bct_cfg_reg u_cfg (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .d    (cfg_in),
        .q    (cfg_q)
    );

    bct_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .setup_live (setup_code),
        .cfg        (cfg_q),
        .ext_ack    (ext_ack),
        .last_beat  (last_beat),
        .state      (state),
        .accept     (accept),
        .beat_done  (beat_done)
    );

    bct_strobe_gen u_stb (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .state   (state),
        .stretch (cfg_q.strobe_ext),
        .strobe  (addr_strobe)
    );

    assign auto_q     = cfg_q.auto_ack;
    assign addr_drive = (state != ST_IDLE);
    assign cs_n       = (state != ST_DATA);
    assign hold_phase = (state == ST_HOLD);
    assign beat_ack   = beat_done;
endmodule

// File: rtl/bct_checker.sv
module bct_checker (
    input logic clk,
    input logic rst,
    input logic addr_drive,
    input logic addr_strobe,
    input logic cs_n,
    input logic beat_ack,
    input logic hold_phase,
    input logic ext_ack,
    input logic auto_q
);
    // R1
    start_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_drive) |-> addr_strobe);

    // R6
    ack_under_cs_chk: assert property (@(posedge clk) disable iff (rst)
        beat_ack |-> !cs_n);

    // R4
    ext_only_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_ack && !auto_q) |-> ext_ack);

    // R2
    strobe_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_strobe && !cs_n) |-> $past(cs_n));

    // R7
    hold_shape_chk: assert property (@(posedge clk) disable iff (rst)
        hold_phase |-> (cs_n && addr_drive));

    // R10
    idle_cs_chk: assert property (@(posedge clk) disable iff (rst)
        !addr_drive |-> (cs_n && !addr_strobe && !beat_ack));

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        hold_phase |=> !addr_strobe);
endmodule

bind bus_cycle_timer bct_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .addr_drive  (addr_drive),
    .addr_strobe (addr_strobe),
    .cs_n        (cs_n),
    .beat_ack    (beat_ack),
    .hold_phase  (hold_phase),
    .ext_ack     (ext_ack),
    .auto_q      (auto_q)
);

// File: tb/bus_cycle_timer_bench.sv
module bus_cycle_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_BEATS  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       is_read = 1'b0;
    logic       last_beat = 1'b0;
    logic       ext_ack = 1'b0;
    logic [1:0] setup_code = '0;
    logic [5:0] wait_pri = '0;
    logic [5:0] wait_sec = '0;
    logic       sec_wait_en = 1'b0;
    logic       auto_ack_en = 1'b0;
    logic [1:0] wr_hold_code = '0;
    logic [1:0] rd_hold_code = '0;
    logic       strobe_ext = 1'b0;
    logic       addr_drive, addr_strobe, cs_n, beat_ack, hold_phase;

    int vectors = 0;
    int miscompares = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_cycle_timer u_bus_cycle_timer (
        .clk(clk), .rst(rst), .start(start), .is_read(is_read),
        .last_beat(last_beat), .ext_ack(ext_ack), .setup_code(setup_code),
        .wait_pri(wait_pri), .wait_sec(wait_sec), .sec_wait_en(sec_wait_en),
        .auto_ack_en(auto_ack_en), .wr_hold_code(wr_hold_code),
        .rd_hold_code(rd_hold_code), .strobe_ext(strobe_ext),
        .addr_drive(addr_drive), .addr_strobe(addr_strobe), .cs_n(cs_n),
        .beat_ack(beat_ack), .hold_phase(hold_phase)
    );

    task automatic chk(string tag, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Runs one complete bus cycle and checks its timeline against the codes.
    task automatic run_cycle(string name, int su, int w, int sw, bit swen,
                             bit aa, int wh, int rh, bit ext, bit rd,
                             int nb, int xd, bit keep_start, bit scramble);
        int strobes = 0;
        int first_cs = -1;
        int beats = 0;
        int dc = 0;
        int holdc = 0;
        int stray = 0;
        int lat[MAX_BEATS];
        int exp_hold;
        for (int b = 0; b < MAX_BEATS; b++) lat[b] = -1;
        @(negedge clk);
        setup_code = su[1:0]; wait_pri = w[5:0]; wait_sec = sw[5:0];
        sec_wait_en = swen; auto_ack_en = aa; wr_hold_code = wh[1:0];
        rd_hold_code = rh[1:0]; strobe_ext = ext; is_read = rd;
        start = 1'b1;
        @(negedge clk);
        if (!keep_start) start = 1'b0;
        if (scramble) begin
            setup_code = ~su[1:0]; wait_pri = ~w[5:0]; wait_sec = ~sw[5:0];
            sec_wait_en = ~swen; auto_ack_en = ~aa; wr_hold_code = ~wh[1:0];
            rd_hold_code = ~rh[1:0]; strobe_ext = ~ext; is_read = ~rd;
        end
        for (int i = 0; i < 400; i++) begin
            last_beat = (beats == nb - 1);
            ext_ack   = !aa && !cs_n && (dc == xd);
            #1;
            if (addr_strobe) strobes++;
            if (!cs_n && first_cs < 0) first_cs = i;
            if (beat_ack && cs_n) stray++;
            if (!cs_n) begin
                if (beat_ack) begin
                    if (beats < MAX_BEATS) lat[beats] = dc + 1;
                    beats++;
                    dc = 0;
                end else begin
                    dc++;
                end
            end
            if (addr_drive && cs_n && beats == nb) holdc++;
            if (!addr_drive) break;
            @(negedge clk);
        end
        start = 1'b0;
        ext_ack = 1'b0;
        last_beat = 1'b0;
        // R1 setup length and strobe at start
        chk("R1", {name, " cs delay"}, first_cs, su + 1);
        // R2 strobe width
        chk("R2", {name, " strobe cycles"}, strobes, ext ? su + 2 : 1);
        // R6 beat count, no ack outside chip select
        chk("R6", {name, " beats"}, beats, nb);
        chk("R6", {name, " stray ack"}, stray, 0);
        for (int b = 0; b < nb; b++) begin
            int e;
            if (!aa) e = xd + 1;
            else if (b > 0 && swen) e = sw + 1;
            else e = w + 1;
            // R3 R4 R5 per-beat latency
            chk(aa ? (swen ? "R5" : "R3") : "R4", {name, " beat latency"}, lat[b], e);
        end
        exp_hold = rd ? (rh + (aa ? 0 : 1)) : (wh + 1);
        chk(rd ? "R8" : "R7", {name, " hold cycles"}, holdc, exp_hold);
        @(negedge clk);
        #1;
        // R9 a start held through the cycle did not restart it
        chk("R9", {name, " idle after cycle"}, int'(addr_drive), 0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        #1;
        // R10 reset state
        chk("R10", "cs_n after reset", int'(cs_n), 1);
        chk("R10", "addr_drive after reset", int'(addr_drive), 0);
        chk("R10", "strobe/ack/hold after reset",
            int'(addr_strobe) + int'(beat_ack) + int'(hold_phase), 0);
    endtask

    task automatic test_basic_write();
        run_cycle("basic write", 0, 2, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0, 0);
    endtask

    task automatic test_long_setup_stretched();
        run_cycle("setup3 stretched read", 3, 0, 0, 0, 1, 0, 0, 1, 1, 1, 0, 0, 0);
    endtask

    task automatic test_external_ack();
        run_cycle("external ack read", 1, 5, 0, 0, 0, 0, 2, 0, 1, 1, 3, 0, 0);
    endtask

    task automatic test_read_hold_zero_noauto();
        run_cycle("read hold0 ext ack", 2, 0, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 0);
    endtask

    task automatic test_burst_secondary();
        run_cycle("burst secondary", 1, 3, 1, 1, 1, 3, 0, 0, 0, 4, 0, 0, 0);
    endtask

    task automatic test_burst_primary();
        run_cycle("burst primary", 0, 2, 7, 0, 1, 1, 0, 0, 0, 3, 0, 0, 0);
    endtask

    task automatic test_start_held();
        run_cycle("start held", 2, 1, 0, 0, 1, 2, 3, 0, 1, 2, 0, 1, 0);
    endtask

    task automatic test_cfg_capture();
        // R11 inputs inverted after acceptance; timing follows captured codes
        run_cycle("R11 capture", 1, 4, 2, 1, 1, 1, 1, 0, 0, 2, 0, 0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_basic_write();
        test_long_setup_stretched();
        test_external_ack();
        test_read_hold_zero_noauto();
        test_burst_secondary();
        test_burst_primary();
        test_start_held();
        test_cfg_capture();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule